// File: doc/BRIEF.md
# Serial Control-Register Slave for a Clock Synthesizer

This block is a two-wire serial slave that holds the small control bank of a spread-spectrum clock generator. A host on the bus addresses the slave and sends a command byte. If the top bit of that byte is set, the low seven bits name a single register to write or read. If the top bit is clear, the command starts a counted block transfer that always begins at register zero. A block write carries a byte count ahead of its data. A block read returns a count supplied by the slave and then the data bytes.

The two lines are sampled on the system clock through synchronizers. The slave never drives a line high: it pulls SDA low by raising an output-enable, and the pad wires that enable to an open-drain driver. The two writable control registers come out as parallel ports, which drive the spread selection and the output-control logic beside the block. All registers take their power-up values on reset, so the host does not have to program anything before the clocks run.

Top module: `clkreg_serial_slave`

## Requirements
- R1: After reset, `ctl_spread_o` is 0x8C, `ctl_output_o` is 0xCC, the ID register at offset 6 reads 0x08, and `sda_oe_o` is low.
- R2: The slave ACKs the address byte 0xD4 (write) and 0xD5 (read), which is 7-bit address 0x6A. For any other address it does not ACK, and it ACKs nothing and changes no register until the next START.
- R3: A command byte with bit 7 = 1 selects a single-byte access at the offset in bits 6:0. A byte write then stores the following data byte in that register. Every byte is ACKed, and a writable register appears on its port after the write.
- R4: A byte read is a command, a repeated START, the read address, and then one data byte, which the slave returns MSB first.
- R5: A command byte with bit 7 = 0 starts a block write. The first data byte is a count N, and the next N bytes fill registers 0, 1, 2 and so on. Bytes beyond N are ACKed but discarded. A STOP after any whole byte leaves the registers not yet reached unchanged.
- R6: A block read returns the count 7 first, then registers 0 to 6 in order, then 0x00 for every further byte, until the master NACKs.
- R7: Writes to offsets 2 to 6 and to offsets of 7 or more are ACKed and discarded. Offsets 2 to 5 and offsets of 7 or more read as 0x00, and offset 6 always reads 0x08.
- R8: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when high |
| ctl_spread_o | output | 8 | Register 0: spread selection and enable |
| ctl_output_o | output | 8 | Register 1: output enables and edge-rate control |

## Verification
An internal fault mostly shows on the bus within the same byte. A wrong bit count or phase moves the ACK slot, so the master reads a missing or stray ACK at the ninth clock. A wrong pointer or count register shows as shifted or wrong data in the next byte read back, or in a block read that starts from a different register. A write decoded to the wrong register shows on the parallel ports one system clock after the eighth data bit. A drive that changes while SCL is high would look to the bus like a START or STOP and derail the transfer at once.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 7;

    typedef enum logic [2:0] {
        BM_IDLE,
        BM_ADDR,
        BM_CMD,
        BM_WR,
        BM_RD,
        BM_SKIP
    } bus_mode_e;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    // Power-up contents of each offset
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h8C;
            1:       return 8'hCC;
            6:       return 8'h08;
            default: return '0;
        endcase
    endfunction

    // Offsets the host may change
    function automatic logic reg_writable(input int idx);
        return (idx == 0) || (idx == 1);
    endfunction

    // Offsets that return their contents (others read as zero)
    function automatic logic reg_readable(input int idx);
        return (idx == 0) || (idx == 1) || (idx == 6);
    endfunction

endpackage

// File: rtl/clkreg_line_sync.sv
module clkreg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], line_i};
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/clkreg_regfile.sv
module clkreg_regfile
    import clkreg_pkg::*;
#(
    parameter int NUM_REGS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr_req,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] reg0_o,
    output logic [DATA_W-1:0] reg1_o
);
    logic [DATA_W-1:0] regq   [NUM_REGS];
    logic [DATA_W-1:0] rd_vec [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (reg_writable(i)) begin : g_rw
            logic [DATA_W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst)
                    q_r <= reg_default(i);
                else if (wr_req.en && wr_req.addr == PTR_W'(i))
                    q_r <= wr_req.data;
            end
            assign regq[i] = q_r;
        end else begin : g_ro
            assign regq[i] = reg_default(i);
        end
        assign rd_vec[i] = reg_readable(i) ? regq[i] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == PTR_W'(k)) rd_data = rd_vec[k];
        end
    end

    assign reg0_o = regq[0];
    assign reg1_o = regq[1];
endmodule

// File: rtl/clkreg_proto_engine.sv
module clkreg_proto_engine
    import clkreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6A,
    parameter int         NUM_REGS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_addr,
    output reg_wr_t           wr_req,
    output logic              sda_oe,
    output bus_mode_e         mode_o
);
    bus_mode_e         mode, next_mode;
    logic [3:0]        bit_cnt;
    logic              in_ack;
    logic              ack_go;
    logic [6:0]        shreg;
    logic              is_block;
    logic              cnt_phase;
    logic              send_count;
    logic              byte_used;
    logic [DATA_W-1:0] blk_left;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] tx;
    logic [DATA_W-1:0] tx_next;
    logic [DATA_W-1:0] rx_byte;
    logic              start_det, stop_det;

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;
    assign rx_byte   = {shreg, sda_lvl};
    assign tx_next   = send_count ? DATA_W'(NUM_REGS) : rd_data;
    assign rd_addr   = ptr;
    assign mode_o    = mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= BM_IDLE;
            next_mode  <= BM_IDLE;
            bit_cnt    <= '0;
            in_ack     <= 1'b0;
            ack_go     <= 1'b0;
            shreg      <= '0;
            is_block   <= 1'b0;
            cnt_phase  <= 1'b0;
            send_count <= 1'b0;
            byte_used  <= 1'b0;
            blk_left   <= '0;
            ptr        <= '0;
            tx         <= '0;
            sda_oe     <= 1'b0;
            wr_req     <= '0;
        end else begin
            wr_req.en <= 1'b0;
            if (start_det) begin
                mode    <= BM_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                mode    <= BM_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (mode == BM_IDLE || mode == BM_SKIP) begin
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                if (in_ack) begin
                    // master acknowledge of a byte the slave sent
                    if (mode == BM_RD) next_mode <= sda_lvl ? BM_SKIP : BM_RD;
                end else if (bit_cnt < 4'd8) begin
                    shreg   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 4'd1;
                    if (bit_cnt == 4'd7 && mode != BM_RD) begin
                        case (mode)
                            BM_ADDR: begin
                                if (rx_byte[7:1] == DEV_ADDR) begin
                                    ack_go     <= 1'b1;
                                    next_mode  <= rx_byte[0] ? BM_RD : BM_CMD;
                                    send_count <= rx_byte[0] & is_block;
                                end else begin
                                    ack_go    <= 1'b0;
                                    next_mode <= BM_SKIP;
                                end
                            end
                            BM_CMD: begin
                                ack_go    <= 1'b1;
                                next_mode <= BM_WR;
                                is_block  <= ~rx_byte[7];
                                cnt_phase <= ~rx_byte[7];
                                byte_used <= 1'b0;
                                ptr       <= rx_byte[7] ? rx_byte[6:0] : '0;
                            end
                            BM_WR: begin
                                ack_go    <= 1'b1;
                                next_mode <= BM_WR;
                                if (is_block) begin
                                    if (cnt_phase) begin
                                        blk_left  <= rx_byte;
                                        cnt_phase <= 1'b0;
                                    end else if (blk_left != '0) begin
                                        wr_req   <= '{en: 1'b1, addr: ptr, data: rx_byte};
                                        ptr      <= ptr + 1'b1;
                                        blk_left <= blk_left - 1'b1;
                                    end
                                end else if (!byte_used) begin
                                    wr_req    <= '{en: 1'b1, addr: ptr, data: rx_byte};
                                    byte_used <= 1'b1;
                                end
                            end
                            default: ack_go <= 1'b0;
                        endcase
                    end
                end
            end else if (scl_fall) begin
                if (in_ack) begin
                    in_ack  <= 1'b0;
                    bit_cnt <= '0;
                    sda_oe  <= 1'b0;
                    mode    <= next_mode;
                    if (next_mode == BM_RD) begin
                        tx     <= tx_next;
                        sda_oe <= ~tx_next[7];
                        if (send_count) send_count <= 1'b0;
                        else            ptr        <= ptr + 1'b1;
                    end
                end else if (bit_cnt == 4'd8) begin
                    in_ack <= 1'b1;
                    sda_oe <= (mode != BM_RD) && ack_go;
                end else if (mode == BM_RD && bit_cnt != 4'd0) begin
                    sda_oe <= ~tx[3'(4'd7 - bit_cnt)];
                end
            end
        end
    end
endmodule

// File: rtl/clkreg_serial_slave.sv
module clkreg_serial_slave
    import clkreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6A,
    parameter int         NUM_REGS    = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] ctl_spread_o,
    output logic [7:0] ctl_output_o
);
    logic              scl_lvl, scl_rise, scl_fall;
    logic              sda_lvl, sda_rise, sda_fall;
    logic [DATA_W-1:0] rd_data;
    logic [PTR_W-1:0]  rd_addr;
    reg_wr_t           wr_req;
    bus_mode_e         bus_mode;

    clkreg_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    clkreg_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    clkreg_proto_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
        .clk(clk), .rst(rst),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_req(wr_req),
        .sda_oe(sda_oe_o), .mode_o(bus_mode)
    );

    clkreg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst(rst), .wr_req(wr_req),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .reg0_o(ctl_spread_o), .reg1_o(ctl_output_o)
    );
endmodule

// File: rtl/clkreg_checker.sv
module clkreg_checker
    import clkreg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [7:0] ctl_spread_o,
    input logic [7:0] ctl_output_o,
    input reg_wr_t    wr_req,
    input bus_mode_e  bus_mode
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i); // R8

    AST_SPREAD_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_spread_o) |-> ($past(wr_req.en) && $past(wr_req.addr) == '0)); // R3

    AST_OUTCFG_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_output_o) |-> ($past(wr_req.en) && $past(wr_req.addr) == 7'd1)); // R3

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (bus_mode == BM_SKIP) |-> !sda_oe_o); // R2

    AST_WRITE_FROM_WR: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> ($past(bus_mode) == BM_WR)); // R5
endmodule

bind clkreg_serial_slave clkreg_checker chk_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .ctl_spread_o(ctl_spread_o), .ctl_output_o(ctl_output_o),
    .wr_req(wr_req), .bus_mode(bus_mode)
);

// File: tb/clkreg_serial_slave_tb_top.sv
`timescale 1ns/1ps
module clkreg_serial_slave_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [7:0] ctl_s, ctl_o;

    int checks = 0;
    int errors = 0;
    int oe_bad = 0;
    logic [7:0] m_s = 8'h8C;
    logic [7:0] m_o = 8'hCC;

    // {offset, write data, expected readback}
    localparam logic [23:0] VEC [6] = '{
        24'h00_5A_5A, 24'h01_33_33, 24'h06_FF_08,
        24'h03_77_00, 24'h40_12_00, 24'h00_A5_A5
    };

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    clkreg_serial_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .ctl_spread_o(ctl_s), .ctl_output_o(ctl_o)
    );

    // R8 monitor: drive changes while SCL high
    always @(sda_oe) if (!rst && scl_m) oe_bad++;

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_n(5);
        scl_m = 1'b1; wait_n(10);
        sda_m = 1'b0; wait_n(10);
        scl_m = 1'b0; wait_n(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(5);
        scl_m = 1'b1; wait_n(10);
        sda_m = 1'b1; wait_n(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(5);
            scl_m = 1'b1; wait_n(10);
            scl_m = 1'b0; wait_n(5);
        end
        sda_m = 1'b1; wait_n(5);
        scl_m = 1'b1; wait_n(5);
        ack = ~sda_line; wait_n(5);
        scl_m = 1'b0; wait_n(5);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_n(5);
            scl_m = 1'b1; wait_n(5);
            b[i] = sda_line; wait_n(5);
            scl_m = 1'b0; wait_n(5);
        end
        sda_m = nack; wait_n(5);
        scl_m = 1'b1; wait_n(10);
        scl_m = 1'b0; wait_n(5);
        sda_m = 1'b1;
    endtask

    task automatic do_wr(input logic [7:0] off, input logic [7:0] data);
        logic a;
        bus_start();
        send_byte(8'hD4, a);             chk8("R2 write address ack", {7'd0, a}, 8'h01);
        send_byte({1'b1, off[6:0]}, a);  chk8("R3 command ack", {7'd0, a}, 8'h01);
        send_byte(data, a);              chk8("R3 data ack", {7'd0, a}, 8'h01);
        bus_stop();
    endtask

    task automatic do_rd(input logic [7:0] off, output logic [7:0] data);
        logic a;
        bus_start();
        send_byte(8'hD4, a);
        send_byte({1'b1, off[6:0]}, a);
        bus_start();
        send_byte(8'hD5, a);             chk8("R2 read address ack", {7'd0, a}, 8'h01);
        recv_byte(1'b1, data);
        bus_stop();
    endtask

    initial begin
        logic [7:0] rd;
        logic a;
        wait_n(6);
        rst = 1'b0;
        wait_n(4);

        // R1 reset state
        chk8("R1 spread reset", ctl_s, 8'h8C);
        chk8("R1 output reset", ctl_o, 8'hCC);
        chk8("R1 sda released", {7'd0, sda_oe}, 8'h00);
        do_rd(8'h06, rd); chk8("R1 id register", rd, 8'h08);
        do_rd(8'h01, rd); chk8("R4 read default reg1", rd, 8'hCC);

        // table of byte write/read vectors (R3 R4 R7)
        for (int v = 0; v < 6; v++) begin
            do_wr(VEC[v][23:16], VEC[v][15:8]);
            if (VEC[v][23:16] == 8'h00) m_s = VEC[v][15:8];
            if (VEC[v][23:16] == 8'h01) m_o = VEC[v][15:8];
            chk8("R3 spread port", ctl_s, m_s);
            chk8("R3 output port", ctl_o, m_o);
            do_rd(VEC[v][23:16], rd);
            chk8("R4 R7 readback", rd, VEC[v][7:0]);
        end

        // R2 wrong address ignored until next START
        bus_start();
        send_byte(8'hA0, a); chk8("R2 foreign address nack", {7'd0, a}, 8'h00);
        send_byte(8'h80, a); chk8("R2 ignored byte nack", {7'd0, a}, 8'h00);
        send_byte(8'h00, a); chk8("R2 ignored data nack", {7'd0, a}, 8'h00);
        bus_stop();
        chk8("R2 spread untouched", ctl_s, 8'hA5);

        // R5 block write with extra byte past count
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h00, a); chk8("R5 block cmd ack", {7'd0, a}, 8'h01);
        send_byte(8'h02, a); chk8("R5 count ack", {7'd0, a}, 8'h01);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h99, a); chk8("R5 extra byte ack", {7'd0, a}, 8'h01);
        bus_stop();
        chk8("R5 block reg0", ctl_s, 8'h11);
        chk8("R5 block reg1", ctl_o, 8'h22);

        // R5 early stop after one data byte
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h00, a);
        send_byte(8'h03, a);
        send_byte(8'h44, a);
        bus_stop();
        chk8("R5 early stop reg0", ctl_s, 8'h44);
        chk8("R5 early stop reg1 kept", ctl_o, 8'h22);

        // R6 block read
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hD5, a);
        recv_byte(1'b0, rd); chk8("R6 count byte", rd, 8'h07);
        for (int k = 0; k < 7; k++) begin
            recv_byte(1'b0, rd);
            chk8("R6 block data", rd,
                 (k == 0) ? 8'h44 : (k == 1) ? 8'h22 : (k == 6) ? 8'h08 : 8'h00);
        end
        recv_byte(1'b1, rd); chk8("R6 past end", rd, 8'h00);
        bus_stop();

        chk8("R8 drive changes with SCL high", oe_bad[7:0], 8'h00);

        // R1 reset again restores defaults
        rst = 1'b1; wait_n(4);
        rst = 1'b0; wait_n(4);
        chk8("R1 spread after reset", ctl_s, 8'h8C);
        chk8("R1 output after reset", ctl_o, 8'hCC);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule